// File: doc/BRIEF.md
# PCIe Cold Reset Timing Monitor

This block watches one PCIe port from the moment its supply is declared good until the link comes up. It timestamps two anchor events: supply good and fundamental-reset release. Against those anchors it times three windows in order. The first is how long reset stays asserted after the supply is good. The second is how long the link state machine takes to reach the Detect state after reset release. The third is how long it takes for the link to become active after reset release. The link counts as active when the reported state is L0 and the receiver is out of electrical idle.

Time is counted in whole milliseconds. A millisecond tick is derived from the clock through the `CLK_PER_MS` parameter, which a testbench may shrink. Every rule that is broken raises its own sticky flag, and a clear pulse resets the flags. A done output shows that the sequence has finished, either because the link is up or because its deadline has passed. The three measured intervals are exposed, so the actual reset-to-active time can be compared with the expected value of about 40 ms. Dropping the supply-good input, or asserting reset again, abandons the current measurement.

Top module: `pcie_crst_monitor`

## Requirements
- R1: After reset all three violation flags, `done_o` and all three interval outputs are 0.
- R2: A measurement starts when `pwr_good_i` is 1 while `perst_n_i` is 0. `ms_hold_o` then reports the number of whole milliseconds (`CLK_PER_MS` clocks each) that `perst_n_i` stayed low before it rose.
- R3: If `perst_n_i` rises after fewer than `MIN_HOLD_MS` whole milliseconds, `viol_hold_o` is set.
- R4: `ms_detect_o` counts whole milliseconds from reset release until `ltssm_i` equals `DETECT_CODE` (default 5'h01), and it stops at `ACTIVE_MAX_MS`. `viol_detect_o` is set once `DETECT_MAX_MS` whole milliseconds pass without Detect.
- R5: After Detect has been seen, the link counts as active on the first cycle with `ltssm_i` equal to `L0_CODE` (default 5'h10) and `rx_elec_idle_i` low. At that point `ms_active_o` holds the whole milliseconds since reset release, and `done_o` rises.
- R6: If `ACTIVE_MAX_MS` whole milliseconds pass after release without an active link, `viol_active_o` and `done_o` are set and `ms_active_o` reads `ACTIVE_MAX_MS`.
- R7: Driving `pwr_good_i` low, or driving `perst_n_i` low after release, ends the measurement and clears `done_o`. A new measurement clears all three interval outputs.
- R8: Each violation flag stays set, even through an aborted measurement, until `viol_clr_i` is pulsed. The clear takes effect one clock later.
- R9: Each interval output saturates at its all-ones value and does not wrap.
- R10: L0 reported while `rx_elec_idle_i` is still high is not an active link. L0 reported before Detect has been seen is not an active link either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply rails stable |
| perst_n_i | input | 1 | Fundamental reset, active low |
| ltssm_i | input | LTSSM_W | Encoded link training state |
| rx_elec_idle_i | input | 1 | Receiver in electrical idle |
| viol_clr_i | input | 1 | Pulse to clear the violation flags |
| viol_hold_o | output | 1 | Reset released too early after supply good |
| viol_detect_o | output | 1 | Detect reached late, or not at all |
| viol_active_o | output | 1 | Link not active within its deadline |
| done_o | output | 1 | Sequence finished (link active or timed out) |
| ms_hold_o | output | CNT_W | Supply good to reset release, in ms |
| ms_detect_o | output | CNT_W | Reset release to Detect, in ms |
| ms_active_o | output | CNT_W | Reset release to link active, in ms |

## Verification
The following rules are checked by assertions on every cycle:
- The flags stay set until they are cleared.
- The Detect and active deadlines raise their flags one cycle after the limit is reached.
- The done output rises only for an active link or a timeout, and falls when the supply drops.
- The interval counters never step by more than one and never leave saturation.
- The millisecond tick never fires on two cycles in a row.

Only the bench's scenarios can show that the counted intervals match the stimulus to the exact millisecond at each boundary. The same holds for the ordering rule that ignores L0 before Detect and L0 while still in electrical idle, and for the clearing of the intervals when a measurement restarts.

// File: rtl/crst_pkg.sv
package crst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAIT_DET,
        ST_WAIT_ACT,
        ST_DONE
    } crst_state_e;

    typedef struct packed {
        crst_state_e st;
        logic        v_hold;
        logic        v_det;
        logic        v_act;
    } crst_regs_t;

    localparam int NUM_WIN = 3;
    localparam int WIN_HOLD = 0;
    localparam int WIN_DET  = 1;
    localparam int WIN_ACT  = 2;

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int CLK_PER_MS = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int SUB_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

    generate
        if (CLK_PER_MS > 1) begin : g_div
            localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_MS - 1);
            logic [SUB_W-1:0] sub_d, sub_q;

            always_comb begin
                sub_d = sub_q;
                if (restart_i || sub_q == SUB_LAST) sub_d = '0;
                else                                sub_d = sub_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sub_q <= '0;
                else        sub_q <= sub_d;
            end

            assign tick_o = (sub_q == SUB_LAST);

            // R2: millisecond ticks are spaced by CLK_PER_MS cycles, never back to back
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_pass
            logic unused_restart;
            assign unused_restart = restart_i;
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/sat_ms_counter.sv
module sat_ms_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                          cnt_d = '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9: once saturated the counter holds its value until cleared
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

    // R2: an interval advances by at most one millisecond per cycle
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pcie_crst_monitor.sv
module pcie_crst_monitor
    import crst_pkg::*;
#(
    parameter int CLK_PER_MS    = 200000,
    parameter int CNT_W         = 16,
    parameter int LTSSM_W       = 5,
    parameter int MIN_HOLD_MS   = 100,
    parameter int DETECT_MAX_MS = 20,
    parameter int ACTIVE_MAX_MS = 100,
    parameter logic [LTSSM_W-1:0] DETECT_CODE = 'h01,
    parameter logic [LTSSM_W-1:0] L0_CODE     = 'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good_i,
    input  logic               perst_n_i,
    input  logic [LTSSM_W-1:0] ltssm_i,
    input  logic               rx_elec_idle_i,
    input  logic               viol_clr_i,
    output logic               viol_hold_o,
    output logic               viol_detect_o,
    output logic               viol_active_o,
    output logic               done_o,
    output logic [CNT_W-1:0]   ms_hold_o,
    output logic [CNT_W-1:0]   ms_detect_o,
    output logic [CNT_W-1:0]   ms_active_o
);
    localparam logic [CNT_W-1:0] HOLD_LIM = CNT_W'(MIN_HOLD_MS);
    localparam logic [CNT_W-1:0] DET_LIM  = CNT_W'(DETECT_MAX_MS);
    localparam logic [CNT_W-1:0] ACT_LIM  = CNT_W'(ACTIVE_MAX_MS);

    crst_regs_t r_d, r_q;

    logic               tick;
    logic               start_meas;
    logic               release_ev;
    logic [NUM_WIN-1:0] win_en;
    logic [CNT_W-1:0]   win_cnt [NUM_WIN];

    logic det_hit, link_up, det_late, act_late, aborted;

    assign det_hit  = (ltssm_i == DETECT_CODE);
    assign link_up  = (ltssm_i == L0_CODE) && !rx_elec_idle_i;
    assign det_late = (win_cnt[WIN_DET] >= DET_LIM);
    assign act_late = (win_cnt[WIN_ACT] >= ACT_LIM);
    assign aborted  = !pwr_good_i || !perst_n_i;

    ms_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_meas | release_ev),
        .tick_o    (tick)
    );

    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            sat_ms_counter #(.W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr_i (start_meas),
                .inc_i (win_en[g] & tick),
                .cnt_o (win_cnt[g])
            );
        end
    endgenerate

    always_comb begin
        r_d        = r_q;
        start_meas = 1'b0;
        release_ev = 1'b0;
        win_en     = '0;
        if (viol_clr_i) begin
            r_d.v_hold = 1'b0;
            r_d.v_det  = 1'b0;
            r_d.v_act  = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (pwr_good_i && !perst_n_i) begin
                    r_d.st     = ST_HOLD;
                    start_meas = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!pwr_good_i) begin
                    r_d.st = ST_IDLE;
                end else if (perst_n_i) begin
                    r_d.st     = ST_WAIT_DET;
                    release_ev = 1'b1;
                    if (win_cnt[WIN_HOLD] < HOLD_LIM) r_d.v_hold = 1'b1;
                end else begin
                    win_en[WIN_HOLD] = 1'b1;
                end
            end
            ST_WAIT_DET: begin
                if (aborted) begin
                    r_d.st = ST_IDLE;
                end else if (act_late) begin
                    r_d.st    = ST_DONE;
                    r_d.v_act = 1'b1;
                    r_d.v_det = 1'b1;
                end else begin
                    win_en[WIN_ACT] = 1'b1;
                    if (det_late) r_d.v_det = 1'b1;
                    if (det_hit) r_d.st = ST_WAIT_ACT;
                    else         win_en[WIN_DET] = 1'b1;
                end
            end
            ST_WAIT_ACT: begin
                if (aborted) begin
                    r_d.st = ST_IDLE;
                end else if (act_late) begin
                    r_d.st    = ST_DONE;
                    r_d.v_act = 1'b1;
                end else if (link_up) begin
                    r_d.st = ST_DONE;
                end else begin
                    win_en[WIN_ACT] = 1'b1;
                end
            end
            ST_DONE: begin
                if (aborted) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, v_hold: 1'b0, v_det: 1'b0, v_act: 1'b0};
        else        r_q <= r_d;
    end

    assign viol_hold_o   = r_q.v_hold;
    assign viol_detect_o = r_q.v_det;
    assign viol_active_o = r_q.v_act;
    assign done_o        = (r_q.st == ST_DONE);
    assign ms_hold_o     = win_cnt[WIN_HOLD];
    assign ms_detect_o   = win_cnt[WIN_DET];
    assign ms_active_o   = win_cnt[WIN_ACT];

    // R8: violation flags persist until a clear pulse
    assert_hold_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_hold_o && !viol_clr_i) |=> viol_hold_o);
    assert_detect_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_detect_o && !viol_clr_i) |=> viol_detect_o);

    // R4: Detect deadline reached while still waiting raises the flag next cycle
    assert_detect_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_DET && det_late && !aborted) |=> viol_detect_o);

    // R6: active deadline ends the sequence with a flag
    assert_active_deadline_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_WAIT_DET || r_q.st == ST_WAIT_ACT) && act_late && !aborted)
        |=> (done_o && viol_active_o));

    // R5: done only rises for a recognised active link or a timeout
    assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(link_up) || viol_active_o));

    // R7: losing supply good drops done
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |=> !done_o);

endmodule

// File: tb/tb_pcie_crst_monitor.sv
`timescale 1ns/1ps
module tb_pcie_crst_monitor;
    localparam int MS     = 4;
    localparam int CW     = 8;
    localparam int HOLD   = 100;
    localparam int DETMAX = 20;
    localparam int ACTMAX = 100;
    localparam logic [4:0] DET_C = 5'h01;
    localparam logic [4:0] L0_C  = 5'h10;
    localparam int WAIT_TOT = 430;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr = 1'b0, perst_n = 1'b0, eidle = 1'b1, clr = 1'b0;
    logic [4:0] ltssm = 5'h00;
    logic v_hold, v_det, v_act, done;
    logic [CW-1:0] t_hold, t_det, t_act;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcie_crst_monitor #(
        .CLK_PER_MS(MS), .CNT_W(CW), .LTSSM_W(5),
        .MIN_HOLD_MS(HOLD), .DETECT_MAX_MS(DETMAX), .ACTIVE_MAX_MS(ACTMAX),
        .DETECT_CODE(DET_C), .L0_CODE(L0_C)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr), .perst_n_i(perst_n),
        .ltssm_i(ltssm), .rx_elec_idle_i(eidle), .viol_clr_i(clr),
        .viol_hold_o(v_hold), .viol_detect_o(v_det), .viol_active_o(v_act),
        .done_o(done), .ms_hold_o(t_hold), .ms_detect_o(t_det), .ms_active_o(t_act)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v > 255) ? 255 : v;
    endfunction

    task automatic cleanup(int ev0, int ev1, int ev2);
        @(negedge clk);
        pwr = 1'b0; perst_n = 1'b0; ltssm = 5'h00; eidle = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 done after abort", int'(done), 0);
        check("R8 flags kept through abort", int'({v_hold, v_det, v_act}), (ev0 << 2) | (ev1 << 1) | ev2);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R8 flags after clear", int'({v_hold, v_det, v_act}), 0);
    endtask

    // h: clocks PERST# held; d, a: clocks after release to Detect / L0 exit from idle
    task automatic scenario(int h, int d, int a, bit has_det, bit has_act);
        int el;
        int e_hold, e_det, e_act, ev0, ev1, ev2;
        bit ok_det, ok_act;
        pwr = 1'b1; perst_n = 1'b0;
        repeat (h + 1) @(negedge clk);
        perst_n = 1'b1;
        el = 0;
        if (!has_det) begin
            ltssm = L0_C; eidle = 1'b0;   // R10: L0 before Detect must not count
        end else begin
            repeat (d + 1) @(negedge clk);
            el = d + 1;
            ltssm = DET_C;
            if (has_act) begin
                repeat (a - d) @(negedge clk);
                el = a + 1;
                ltssm = L0_C; eidle = 1'b0;
            end else begin
                @(negedge clk);
                el = el + 1;
                ltssm = L0_C;              // R10: L0 still in electrical idle
            end
        end
        repeat (WAIT_TOT - el) @(negedge clk);
        ok_det = has_det && (d / MS) < ACTMAX;
        ok_act = ok_det && has_act && (a / MS) < ACTMAX;
        e_hold = sat(h / MS);
        e_det  = ok_det ? d / MS : ACTMAX;
        e_act  = ok_act ? a / MS : ACTMAX;
        ev0 = ((h / MS) < HOLD) ? 1 : 0;
        ev1 = (!ok_det || (d / MS) >= DETECT_MAX_CHECK()) ? 1 : 0;
        ev2 = ok_act ? 0 : 1;
        check("R5 R6 done", int'(done), 1);
        check("R2 R9 hold interval", int'(t_hold), e_hold);
        check("R3 hold flag", int'(v_hold), ev0);
        check("R4 detect interval", int'(t_det), e_det);
        check("R4 detect flag", int'(v_det), ev1);
        check("R5 R10 active interval", int'(t_act), e_act);
        check("R6 R10 active flag", int'(v_act), ev2);
        cleanup(ev0, ev1, ev2);
    endtask

    function automatic int DETECT_MAX_CHECK();
        return DETMAX;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset flags", int'({v_hold, v_det, v_act, done}), 0);
        check("R1 reset intervals", int'(t_hold) + int'(t_det) + int'(t_act), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'(done), 0);

        scenario(420, 40, 160, 1, 1);    // nominal, 40 ms to active
        scenario(399, 10, 100, 1, 1);    // hold 99 ms: R3 flag
        scenario(400, 10, 100, 1, 1);    // hold exactly 100 ms: no flag
        scenario(400, 79, 200, 1, 1);    // detect at 19 ms
        scenario(400, 80, 200, 1, 1);    // detect at 20 ms: R4 flag
        scenario(400, 20, 399, 1, 1);    // active at 99 ms
        scenario(400, 20, 400, 1, 1);    // active at 100 ms: R6 flag
        scenario(400, 0, 0, 0, 0);       // never Detect, L0 early ignored (R10)
        scenario(400, 30, 0, 1, 0);      // L0 with idle high ignored (R10)
        scenario(1100, 20, 120, 1, 1);   // R9 saturation of the hold interval

        // R7: abort by reasserting PERST# mid-sequence, new measurement starts clean
        pwr = 1'b1; perst_n = 1'b0;
        repeat (401) @(negedge clk);
        perst_n = 1'b1;
        repeat (11) @(negedge clk);
        ltssm = DET_C;
        repeat (100) @(negedge clk);
        perst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 done after PERST reassert", int'(done), 0);
        check("R7 intervals cleared on restart", int'(t_hold) + int'(t_det) + int'(t_act), 0);
        cleanup(0, 0, 0);

        for (int i = 0; i < 22; i++) begin
            int h, d, a;
            bit hd, ha;
            h  = ($urandom % 2 == 0) ? 392 + int'($urandom % 16) : 200 + int'($urandom % 400);
            d  = ($urandom % 2 == 0) ? 72 + int'($urandom % 16) : int'($urandom % 300);
            a  = ($urandom % 2 == 0) ? 392 + int'($urandom % 16) : d + 1 + int'($urandom % 300);
            if (a <= d) a = d + 1;
            if (a > 424) a = 424;
            hd = ($urandom % 10) != 0;
            ha = ($urandom % 10) != 0;
            scenario(h, d, a, hd, ha);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule